// File: doc/BRIEF.md
# Blinking Floor Seven-Segment Display

This block drives one seven-segment digit that shows the floor an elevator car is standing at or passing. A floor number in the range 0 to 4 is decoded into an active-high segment pattern; any other value leaves the digit dark. The display needs no digit-select line, so the block produces only the seven segment bits.

When the motor controller signals that the car has arrived at a floor, the block flashes the digit five times and then returns to a steady display. Each flash is an on half followed by an all-dark half. Both halves are measured in pulses of a slow timing tick supplied from outside, so the flash rate follows whatever tick rate the chip provides. With a tick every 0.5 s / `HALF_TICKS`, each flash lasts one second and the whole sequence lasts five. A blink-active flag stays high for the whole sequence.

Top module: `floor_blink_display`

## Requirements
- R1: Segment outputs are active high with segment a in bit 6 down to segment g in bit 0. The codes are: floor 0 = 7'h7E, 1 = 7'h30, 2 = 7'h6D, 3 = 7'h79, 4 = 7'h33.
- R2: A floor value of `NUM_FLOORS` (5) or more drives all segments to 0 at all times.
- R3: After reset, and whenever no blink sequence is running, `blink_o` is 0 and `seg_o` shows the decoded current floor. Ticks that arrive while idle leave it so.
- R4: In the cycle after `arrive_i` is sampled high, `blink_o` is 1 and the digit is lit (the sequence starts with an on half).
- R5: During a sequence each half lasts `HALF_TICKS` tick pulses. In an on half `seg_o` equals the decoded floor (following `floor_i` without delay). In an off half `seg_o` is 0.
- R6: A sequence holds `BLINKS` (5) on/off pairs. `blink_o` falls in the cycle after the tick that ends the fifth off half. That is `2*HALF_TICKS*BLINKS` ticks after the start.
- R7: An arrival pulse during a sequence restarts it from the on half of the first flash. An arrival wins over a tick sampled in the same cycle.
- R8: Without a tick or an arrival the sequence state does not advance, whatever the number of clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| floor_i | input | 3 | Current floor number |
| arrive_i | input | 1 | One-cycle pulse: the car has stopped at a floor |
| tick_i | input | 1 | One-cycle slow timing pulse that paces the flashing |
| seg_o | output | 7 | Segments a..g, bit 6..0, active high |
| blink_o | output | 1 | High while a flash sequence is running |

## Verification
The flash timer advancing on a tick and an arrival restarting the sequence can fall in the same cycle. The bench drives both together while the digit is in an off half. It then judges that the next cycle shows the new floor lit with `blink_o` high. It also judges that a full `2*HALF_TICKS*BLINKS` ticks are again needed before the flag falls, with the flag still high one tick earlier. A floor change in mid-flash overlaps the blink gating in the same way, and is judged on the same cycle at the segment outputs.

// File: rtl/fbd_pkg.sv
package fbd_pkg;

  localparam int SEG_W = 7;

  typedef logic [SEG_W-1:0] seg_t;

  // Active-high pattern for a decimal digit, segment a in the top bit.
  function automatic seg_t seg_digit(input int unsigned d);
    seg_t p;
    case (d)
      0: p = 7'b1111110;
      1: p = 7'b0110000;
      2: p = 7'b1101101;
      3: p = 7'b1111001;
      4: p = 7'b0110011;
      5: p = 7'b1011011;
      6: p = 7'b1011111;
      7: p = 7'b1110000;
      8: p = 7'b1111111;
      9: p = 7'b1111011;
      default: p = '0;
    endcase
    return p;
  endfunction

  // Decode with range limit: out-of-range floors give a dark digit.
  function automatic seg_t floor_pattern(input int unsigned fl, input int unsigned n_floors);
    if (fl >= n_floors) return '0;
    return seg_digit(fl);
  endfunction

  function automatic int unsigned cnt_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/fbd_seg_decoder.sv
module fbd_seg_decoder
  import fbd_pkg::*;
#(
  parameter int FLOOR_W    = 3,
  parameter int NUM_FLOORS = 5
) (
  input  logic [FLOOR_W-1:0] floor_i,
  output seg_t               raw_o
);
  int unsigned fl;

  always_comb begin
    fl    = 32'(floor_i);
    raw_o = floor_pattern(fl, NUM_FLOORS);
  end
endmodule

// File: rtl/fbd_blink_seq.sv
module fbd_blink_seq
  import fbd_pkg::*;
#(
  parameter int HALF_TICKS = 4,
  parameter int BLINKS     = 5,
  parameter int HALF_W     = cnt_width(HALF_TICKS),
  parameter int COUNT_W    = cnt_width(BLINKS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               arrive_i,
  input  logic               tick_i,
  output logic               active_o,
  output logic               off_phase_o,
  output logic [COUNT_W-1:0] blink_idx_o,
  output logic               half_done_o,
  output logic               seq_done_o
);
  localparam logic [HALF_W-1:0]  HALF_LAST  = HALF_W'(HALF_TICKS - 1);
  localparam logic [COUNT_W-1:0] BLINK_LAST = COUNT_W'(BLINKS - 1);

  logic [HALF_W-1:0] half_cnt;

  assign half_done_o = active_o && tick_i && (half_cnt == HALF_LAST);
  assign seq_done_o  = half_done_o && off_phase_o && (blink_idx_o == BLINK_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_o    <= 1'b0;
      off_phase_o <= 1'b0;
      blink_idx_o <= '0;
      half_cnt    <= '0;
    end else if (arrive_i) begin
      active_o    <= 1'b1;
      off_phase_o <= 1'b0;
      blink_idx_o <= '0;
      half_cnt    <= '0;
    end else if (active_o && tick_i) begin
      if (half_done_o) begin
        half_cnt <= '0;
        if (!off_phase_o) begin
          off_phase_o <= 1'b1;
        end else if (seq_done_o) begin
          active_o    <= 1'b0;
          off_phase_o <= 1'b0;
          blink_idx_o <= '0;
        end else begin
          off_phase_o <= 1'b0;
          blink_idx_o <= blink_idx_o + 1'b1;
        end
      end else begin
        half_cnt <= half_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/fbd_seg_gate.sv
module fbd_seg_gate
  import fbd_pkg::*;
(
  input  seg_t raw_i,
  input  logic show_i,
  output seg_t seg_o
);
  for (genvar i = 0; i < SEG_W; i++) begin : g_seg
    assign seg_o[i] = raw_i[i] & show_i;
  end
endmodule

// File: rtl/floor_blink_display.sv
module floor_blink_display
  import fbd_pkg::*;
#(
  parameter int FLOOR_W    = 3,
  parameter int NUM_FLOORS = 5,
  parameter int HALF_TICKS = 4,
  parameter int BLINKS     = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [FLOOR_W-1:0] floor_i,
  input  logic               arrive_i,
  input  logic               tick_i,
  output logic [6:0]         seg_o,
  output logic               blink_o
);
  localparam int COUNT_W = cnt_width(BLINKS);

  seg_t               raw_seg;
  logic               off_phase;
  logic [COUNT_W-1:0] blink_idx;
  logic               half_done;
  logic               seq_done;
  logic               show;

  fbd_seg_decoder #(.FLOOR_W(FLOOR_W), .NUM_FLOORS(NUM_FLOORS)) u_dec (
    .floor_i (floor_i),
    .raw_o   (raw_seg)
  );

  fbd_blink_seq #(.HALF_TICKS(HALF_TICKS), .BLINKS(BLINKS)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .arrive_i    (arrive_i),
    .tick_i      (tick_i),
    .active_o    (blink_o),
    .off_phase_o (off_phase),
    .blink_idx_o (blink_idx),
    .half_done_o (half_done),
    .seq_done_o  (seq_done)
  );

  assign show = !(blink_o && off_phase);

  fbd_seg_gate u_gate (
    .raw_i  (raw_seg),
    .show_i (show),
    .seg_o  (seg_o)
  );
endmodule

// File: rtl/floor_blink_display_chk.sv
module floor_blink_display_chk
  import fbd_pkg::*;
#(
  parameter int FLOOR_W    = 3,
  parameter int NUM_FLOORS = 5,
  parameter int BLINKS     = 5,
  parameter int COUNT_W    = cnt_width(BLINKS)
) (
  input logic               clk,
  input logic               rst_n,
  input logic [FLOOR_W-1:0] floor_i,
  input logic               arrive_i,
  input logic               tick_i,
  input logic [6:0]         seg_o,
  input logic               blink_o,
  input logic               off_phase,
  input logic [COUNT_W-1:0] blink_idx,
  input logic               half_done,
  input logic               seq_done
);
  assert_range_dark_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(floor_i) >= NUM_FLOORS) |-> (seg_o == 7'd0));

  assert_idle_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !blink_o |-> (seg_o == seg_digit(32'(floor_i)) || 32'(floor_i) >= NUM_FLOORS));

  assert_start_lit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    arrive_i |=> (blink_o && !off_phase));

  assert_dark_off_half_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (blink_o && off_phase) |-> (seg_o == 7'd0));

  assert_end_timing_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(blink_o) |-> ($past(tick_i) && $past(off_phase) &&
                        $past(blink_idx) == COUNT_W'(BLINKS - 1)));

  assert_done_ends_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_done && !arrive_i) |=> !blink_o);

  assert_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (arrive_i && blink_o) |=> (blink_o && !off_phase && blink_idx == '0));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!arrive_i && !tick_i) |=> ($stable(blink_o) && $stable(off_phase) && $stable(blink_idx)));

  assert_half_needs_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
    half_done |-> tick_i);
endmodule

bind floor_blink_display floor_blink_display_chk #(
  .FLOOR_W(FLOOR_W), .NUM_FLOORS(NUM_FLOORS), .BLINKS(BLINKS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .floor_i   (floor_i),
  .arrive_i  (arrive_i),
  .tick_i    (tick_i),
  .seg_o     (seg_o),
  .blink_o   (blink_o),
  .off_phase (off_phase),
  .blink_idx (blink_idx),
  .half_done (half_done),
  .seq_done  (seq_done)
);

// File: tb/sim_floor_blink_display.sv
`timescale 1ns/1ps
module sim_floor_blink_display;
  localparam int HT = 4;
  localparam int NB = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] floor_i = 3'd0;
  logic       arrive_i = 1'b0;
  logic       tick_i = 1'b0;
  logic [6:0] seg_o;
  logic       blink_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  floor_blink_display #(.HALF_TICKS(HT), .BLINKS(NB)) u0 (
    .clk(clk), .rst_n(rst_n), .floor_i(floor_i),
    .arrive_i(arrive_i), .tick_i(tick_i), .seg_o(seg_o), .blink_o(blink_o)
  );

  // {floor, expected segments a..g}
  localparam logic [9:0] VEC [8] = '{
    {3'd0, 7'h7E}, {3'd1, 7'h30}, {3'd2, 7'h6D}, {3'd3, 7'h79},
    {3'd4, 7'h33}, {3'd5, 7'h00}, {3'd6, 7'h00}, {3'd7, 7'h00}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic a, input logic t);
    arrive_i = a;
    tick_i   = t;
    @(posedge clk);
    #1;
    arrive_i = 1'b0;
    tick_i   = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    check(blink_o == 1'b0, "R3 reset flag", blink_o, 0);
    check(seg_o == 7'h7E, "R3 reset digit", seg_o, 7'h7E);

    // Decode table, idle, with a tick applied each time.
    for (int i = 0; i < 8; i++) begin
      floor_i = VEC[i][9:7];
      #1;
      check(seg_o == VEC[i][6:0], (i < 5) ? "R1 decode" : "R2 out of range",
            seg_o, VEC[i][6:0]);
      cyc(1'b0, 1'b1);
      check(blink_o == 1'b0 && seg_o == VEC[i][6:0], "R3 idle tick",
            {blink_o, seg_o}, {1'b0, VEC[i][6:0]});
    end

    // Full sequence on floor 2.
    floor_i = 3'd2;
    cyc(1'b1, 1'b0);
    check(blink_o && seg_o == 7'h6D, "R4 start", {blink_o, seg_o}, {1'b1, 7'h6D});
    for (int b = 0; b < NB; b++) begin
      for (int h = 0; h < HT; h++) begin
        check(blink_o && seg_o == 7'h6D, "R5 on half", {blink_o, seg_o}, {1'b1, 7'h6D});
        cyc(1'b0, 1'b1);
      end
      for (int h = 0; h < HT; h++) begin
        check(blink_o && seg_o == 7'h00, "R5 off half", {blink_o, seg_o}, {1'b1, 7'h00});
        cyc(1'b0, 1'b1);
      end
    end
    check(!blink_o && seg_o == 7'h6D, "R6 end of sequence", {blink_o, seg_o}, {1'b0, 7'h6D});

    // No ticks: nothing advances.
    floor_i = 3'd1;
    cyc(1'b1, 1'b0);
    for (int k = 0; k < 10; k++) cyc(1'b0, 1'b0);
    check(blink_o && seg_o == 7'h30, "R8 hold on half", {blink_o, seg_o}, {1'b1, 7'h30});
    for (int k = 0; k < HT; k++) cyc(1'b0, 1'b1);
    for (int k = 0; k < 7; k++) cyc(1'b0, 1'b0);
    check(blink_o && seg_o == 7'h00, "R8 hold off half", {blink_o, seg_o}, {1'b1, 7'h00});

    // Arrival together with a tick in an off half: restart wins.
    floor_i = 3'd3;
    cyc(1'b1, 1'b1);
    check(blink_o && seg_o == 7'h79, "R7 restart lit", {blink_o, seg_o}, {1'b1, 7'h79});
    for (int k = 0; k < 2*HT*NB - 1; k++) cyc(1'b0, 1'b1);
    check(blink_o == 1'b1, "R7 full length after restart", blink_o, 1);
    cyc(1'b0, 1'b1);
    check(blink_o == 1'b0, "R6 falls after last tick", blink_o, 0);

    // Floor changes while lit, including out of range.
    cyc(1'b1, 1'b0);
    floor_i = 3'd4;
    #1;
    check(seg_o == 7'h33, "R5 follows floor", seg_o, 7'h33);
    floor_i = 3'd6;
    #1;
    check(seg_o == 7'h00, "R2 dark while blinking", seg_o, 7'h00);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule